// File: doc/BRIEF.md
# Delay Window Boundary Scanner

This block searches for one edge of the passing region of a programmable receive or transmit delay line. A scan is started with a mode that selects the axis being swept (receive or transmit) and the edge being sought (low or high), a fixed code for the other axis, and a starting read-delay value. For each candidate setting the block first loads the triple (receive code, transmit code, read delay) into the delay line with a load-and-resynchronise strobe. It then asks an external pattern checker whether a known pattern reads back correctly, and waits for the answer.

The inner loop walks the swept axis over a bounded part of its range. The low edge walks upward from code 0 and the high edge walks downward from the top code. The end code of the walk differs for each axis and edge. When an inner walk produces no pass, the read delay is raised by one and the walk restarts from its first code. The scan ends at the first passing setting and returns that full triple. If the read delay runs past its limit, the scan ends with a not-found status instead. Each accepted start produces one done pulse.

Top module: `dly_edge_scan`

## Requirements
- R1: After reset, busy, done, found, chk_req, dl_wr and dl_resync are all low.
- R2: Mode bit 0 selects the swept axis (0 receive, 1 transmit) and mode bit 1 selects the edge (0 low, 1 high). A low-edge scan offers codes 0, 1, 2 and upward, with the receive walk ending after code 15 and the transmit walk ending after code 32.
- R3: A high-edge scan offers codes 63, 62 and downward, with the receive walk ending after code 25 and the transmit walk ending after code 48.
- R4: Throughout a scan the axis that is not swept carries the fixed_code value captured at start.
- R5: When a whole inner walk fails, the next candidate uses the read delay plus one and the first code of the walk again.
- R6: The first candidate uses rd_init as its read delay. A scan whose walk at read delay 4 fails ends not-found. An rd_init above 4 ends not-found without issuing any check.
- R7: The scan stops at the first candidate whose check passes, raises found with done, and presents that candidate on res_rx, res_tx and res_rd. A pass on the very last candidate of the last read delay is reported as found.
- R8: Each candidate is presented with a one-cycle dl_wr and dl_resync pulse before chk_req rises. chk_req is then held, with the candidate stable, until chk_ack, and only one check is outstanding at a time.
- R9: Every accepted start yields exactly one one-cycle done pulse. busy is high from the cycle after the start until the done cycle.
- R10: A start seen while busy is high, including the done cycle, has no effect on the scan in progress and starts no new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan when idle |
| mode | input | 2 | Bit 0 axis (1 = transmit), bit 1 edge (1 = high) |
| fixed_code | input | CODE_W | Code held on the axis not being swept |
| rd_init | input | RD_W | First read-delay value |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | Last scan ended on a passing setting |
| res_rx | output | CODE_W | Receive code of the passing setting |
| res_tx | output | CODE_W | Transmit code of the passing setting |
| res_rd | output | RD_W | Read delay of the passing setting |
| dl_rx | output | CODE_W | Candidate receive code to the delay line |
| dl_tx | output | CODE_W | Candidate transmit code to the delay line |
| dl_rd | output | RD_W | Candidate read delay |
| dl_wr | output | 1 | Delay-line load strobe |
| dl_resync | output | 1 | Delay-line resynchronise strobe |
| chk_req | output | 1 | Pattern check request |
| chk_ack | input | 1 | Pattern check answer strobe |
| chk_pass | input | 1 | Check result, valid with chk_ack |

## Verification
On the last candidate of the last read delay, two events meet in one answer: the inner walk is exhausted and the read delay has reached its limit. That same answer may also be a pass. The bench places a passing point there and expects found. It also arranges the opposite case, where nothing passes, and expects not-found with no fifth read delay attempted. A second collision is a start raised in the very cycle done is high, or in the middle of a scan. These are judged by the probe sequence, the result triple and the count of done pulses, all of which must match a single unperturbed scan.

// File: rtl/dly_scan_pkg.sv
package dly_scan_pkg;

   localparam logic [1:0] MODE_RX_LOW  = 2'b00;
   localparam logic [1:0] MODE_TX_LOW  = 2'b01;
   localparam logic [1:0] MODE_RX_HIGH = 2'b10;
   localparam logic [1:0] MODE_TX_HIGH = 2'b11;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_APPLY = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FIN   = 2'd3
   } scan_state_e;

   function automatic logic sweeps_tx(input logic [1:0] m);
      return m[0];
   endfunction

   function automatic logic walks_down(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/dly_code_walker.sv
module dly_code_walker
   import dly_scan_pkg::*;
#(
   parameter int CODE_W      = 6,
   parameter int RX_LOW_END  = 15,
   parameter int TX_LOW_END  = 32,
   parameter int RX_HIGH_END = 25,
   parameter int TX_HIGH_END = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              active,
   input  logic [1:0]        mode_sel,
   output logic [CODE_W-1:0] code,
   output logic              at_end
);

   localparam int CODE_MAX = (1 << CODE_W) - 1;

   logic [CODE_W-1:0] end_tab [4];

   generate
      for (genvar g = 0; g < 4; g++) begin : g_end
         localparam int END_V = (g == 0) ? RX_LOW_END :
                                (g == 1) ? TX_LOW_END :
                                (g == 2) ? RX_HIGH_END : TX_HIGH_END;
         if (END_V < 0 || END_V > CODE_MAX) begin : g_bad_end
            $error("walk end code out of range for mode %0d", g);
         end
         assign end_tab[g] = CODE_W'(END_V);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
      end else if (load) begin
         code <= walks_down(mode_sel) ? CODE_W'(CODE_MAX) : '0;
      end else if (step) begin
         code <= walks_down(mode_sel) ? code - 1'b1 : code + 1'b1;
      end
   end

   assign at_end = (code == end_tab[mode_sel]);

   // R2: an upward walk never passes its end code
   a_r2_low_walk_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !walks_down(mode_sel)) |-> (code <= end_tab[mode_sel]));

   // R3: a downward walk never passes its end code
   a_r3_high_walk_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (active && walks_down(mode_sel)) |-> (code >= end_tab[mode_sel]));

   // R2/R3: a step is never requested at the end code
   a_r5_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !at_end);

endmodule

// File: rtl/dly_rd_stepper.sv
module dly_rd_stepper #(
   parameter int RD_W   = 3,
   parameter int RD_MAX = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            inc,
   input  logic [RD_W-1:0] rd_init,
   output logic [RD_W-1:0] rd,
   output logic            at_max,
   output logic            init_beyond
);

   localparam int RD_TOP = (1 << RD_W) - 1;

   generate
      if (RD_MAX < 0 || RD_MAX > RD_TOP) begin : g_bad_rd
         $error("RD_MAX does not fit in RD_W bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd <= '0;
      end else if (load) begin
         rd <= rd_init;
      end else if (inc) begin
         rd <= rd + 1'b1;
      end
   end

   assign at_max      = (rd == RD_W'(RD_MAX));
   assign init_beyond = (rd_init > RD_W'(RD_MAX));

   // R6: the read delay is never advanced beyond its limit
   a_r6_no_inc_at_max: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !at_max);

endmodule

// File: rtl/dly_edge_scan.sv
module dly_edge_scan
   import dly_scan_pkg::*;
#(
   parameter int CODE_W      = 6,
   parameter int RD_W        = 3,
   parameter int RD_MAX      = 4,
   parameter int RX_LOW_END  = 15,
   parameter int TX_LOW_END  = 32,
   parameter int RX_HIGH_END = 25,
   parameter int TX_HIGH_END = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [CODE_W-1:0] fixed_code,
   input  logic [RD_W-1:0]   rd_init,
   output logic              busy,
   output logic              done,
   output logic              found,
   output logic [CODE_W-1:0] res_rx,
   output logic [CODE_W-1:0] res_tx,
   output logic [RD_W-1:0]   res_rd,
   output logic [CODE_W-1:0] dl_rx,
   output logic [CODE_W-1:0] dl_tx,
   output logic [RD_W-1:0]   dl_rd,
   output logic              dl_wr,
   output logic              dl_resync,
   output logic              chk_req,
   input  logic              chk_ack,
   input  logic              chk_pass
);

   scan_state_e       state;
   logic [1:0]        mode_q;
   logic [CODE_W-1:0] fixed_q;
   logic              found_q;
   logic [CODE_W-1:0] code;
   logic              at_end;
   logic [RD_W-1:0]   rd;
   logic              at_max;
   logic              init_beyond;

   logic              accept;
   logic              miss;
   logic              hit;
   logic              rd_adv;
   logic              walk_load;
   logic              walk_step;
   logic [1:0]        mode_sel;

   assign accept    = (state == ST_IDLE) && start;
   assign hit       = (state == ST_WAIT) && chk_ack && chk_pass;
   assign miss      = (state == ST_WAIT) && chk_ack && !chk_pass;
   assign rd_adv    = miss && at_end && !at_max;
   assign walk_step = miss && !at_end;
   assign walk_load = accept || rd_adv;
   assign mode_sel  = accept ? mode : mode_q;

   dly_code_walker #(
      .CODE_W      (CODE_W),
      .RX_LOW_END  (RX_LOW_END),
      .TX_LOW_END  (TX_LOW_END),
      .RX_HIGH_END (RX_HIGH_END),
      .TX_HIGH_END (TX_HIGH_END)
   ) u_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (walk_load),
      .step     (walk_step),
      .active   (busy),
      .mode_sel (mode_sel),
      .code     (code),
      .at_end   (at_end)
   );

   dly_rd_stepper #(
      .RD_W   (RD_W),
      .RD_MAX (RD_MAX)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (accept),
      .inc         (rd_adv),
      .rd_init     (rd_init),
      .rd          (rd),
      .at_max      (at_max),
      .init_beyond (init_beyond)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         mode_q  <= '0;
         fixed_q <= '0;
         found_q <= 1'b0;
         res_rx  <= '0;
         res_tx  <= '0;
         res_rd  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  mode_q  <= mode;
                  fixed_q <= fixed_code;
                  found_q <= 1'b0;
                  state   <= init_beyond ? ST_FIN : ST_APPLY;
               end
            end
            ST_APPLY: state <= ST_WAIT;
            ST_WAIT: begin
               if (hit) begin
                  found_q <= 1'b1;
                  res_rx  <= dl_rx;
                  res_tx  <= dl_tx;
                  res_rd  <= dl_rd;
                  state   <= ST_FIN;
               end else if (miss) begin
                  state <= (at_end && at_max) ? ST_FIN : ST_APPLY;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_FIN);
   assign found     = found_q;
   assign dl_wr     = (state == ST_APPLY);
   assign dl_resync = (state == ST_APPLY);
   assign chk_req   = (state == ST_WAIT);
   assign dl_rx     = sweeps_tx(mode_q) ? fixed_q : code;
   assign dl_tx     = sweeps_tx(mode_q) ? code : fixed_q;
   assign dl_rd     = rd;

   // R8: a check is requested only right after a delay-line load
   a_r8_req_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chk_req) |-> $past(dl_wr));

   // R8: request is held until answered
   a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_req && !chk_ack) |=> chk_req);

   // R8: candidate is stable while a check is outstanding
   a_r8_cand_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_req && $past(chk_req)) |-> $stable({dl_rx, dl_tx, dl_rd}));

   // R9: done lasts one cycle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: an idle start makes the block busy
   a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   // R5: the read delay never falls within a scan
   a_r5_rd_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(done)) |-> (dl_rd >= $past(dl_rd)));

   // R7: found is reported only after a passing answer
   a_r7_found_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> $past(chk_ack && chk_pass));

endmodule

// File: tb/dly_edge_scan_bench.sv
module dly_edge_scan_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [5:0] fixed_code = '0;
   logic [2:0] rd_init = 3'd1;
   logic       busy, done, found;
   logic [5:0] res_rx, res_tx, dl_rx, dl_tx;
   logic [2:0] res_rd, dl_rd;
   logic       dl_wr, dl_resync, chk_req;
   logic       chk_ack = 1'b0;
   logic       chk_pass = 1'b0;

   always #10 clk = ~clk;

   dly_edge_scan u_dly_edge_scan (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .fixed_code(fixed_code), .rd_init(rd_init), .busy(busy), .done(done),
      .found(found), .res_rx(res_rx), .res_tx(res_tx), .res_rd(res_rd),
      .dl_rx(dl_rx), .dl_tx(dl_tx), .dl_rd(dl_rd), .dl_wr(dl_wr),
      .dl_resync(dl_resync), .chk_req(chk_req), .chk_ack(chk_ack),
      .chk_pass(chk_pass)
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   // pass window of the modelled flash
   int win_lo, win_hi, win_rd, lat;
   bit win_tx;

   int nprobe = 0;
   int wr_cnt = 0;
   int rs_cnt = 0;
   int done_cnt = 0;
   int log_rx [512];
   int log_tx [512];
   int log_rd [512];

   function automatic bit pass_fn(int rx, int tx, int rd);
      int c;
      c = win_tx ? tx : rx;
      return (rd >= win_rd) && (c >= win_lo) && (c <= win_hi);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // pattern-check responder
   initial begin
      int wcnt;
      wcnt = 0;
      forever begin
         @(negedge clk);
         if (chk_ack) begin
            chk_ack  = 1'b0;
            chk_pass = 1'b0;
         end else if (chk_req) begin
            wcnt++;
            if (wcnt >= lat) begin
               wcnt = 0;
               if (nprobe < 512) begin
                  log_rx[nprobe] = int'(dl_rx);
                  log_tx[nprobe] = int'(dl_tx);
                  log_rd[nprobe] = int'(dl_rd);
               end
               nprobe++;
               chk_pass = pass_fn(int'(dl_rx), int'(dl_tx), int'(dl_rd));
               chk_ack  = 1'b1;
            end
         end
      end
   end

   // strobe monitor
   initial begin
      forever begin
         @(negedge clk);
         if (dl_wr) wr_cnt++;
         if (dl_resync) rs_cnt++;
         if (done) done_cnt++;
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL R9 watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   // one scan: model, stimulus, checks
   task automatic run_scan(input logic [1:0] m, input int fx, input int r0,
                           input int lat_i, input int wlo, input int whi,
                           input int wrd, input bit inj_mid, input bit inj_done,
                           input string tag);
      int e_n, e_rx[512], e_tx[512], e_rd[512];
      bit e_found;
      int cnt, endc, cyc, bad;
      bit up;
      win_tx = m[0]; win_lo = wlo; win_hi = whi; win_rd = wrd; lat = lat_i;
      up = !m[1];
      endc = (m == 2'b00) ? 15 : (m == 2'b01) ? 32 : (m == 2'b10) ? 25 : 48;
      cnt  = up ? endc + 1 : 64 - endc;
      e_n = 0; e_found = 0;
      for (int r = r0; r <= 4 && !e_found; r++) begin
         for (int k = 0; k < cnt && !e_found; k++) begin
            int c;
            c = up ? k : 63 - k;
            e_rx[e_n] = m[0] ? fx : c;
            e_tx[e_n] = m[0] ? c : fx;
            e_rd[e_n] = r;
            if (pass_fn(e_rx[e_n], e_tx[e_n], r)) e_found = 1;
            e_n++;
         end
      end
      @(negedge clk);
      nprobe = 0; wr_cnt = 0; rs_cnt = 0; done_cnt = 0;
      mode = m; fixed_code = 6'(fx); rd_init = 3'(r0); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R9", {tag, " busy after start"}, int'(busy), 1);
      cyc = 0;
      while (!done && cyc < 20000) begin
         if (inj_mid && cyc == 5) begin
            start = 1'b1; mode = ~m; fixed_code = ~6'(fx); rd_init = 3'd4;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      check(done == 1'b1, "R9", {tag, " done seen"}, int'(done), 1);
      check(found == e_found, "R7", {tag, " found"}, int'(found), int'(e_found));
      if (e_found) begin
         check(int'(res_rx) == e_rx[e_n-1] && int'(res_tx) == e_tx[e_n-1] &&
               int'(res_rd) == e_rd[e_n-1], "R7", {tag, " result triple"},
               int'({res_rx, res_tx, res_rd}),
               (e_rx[e_n-1] << 9) | (e_tx[e_n-1] << 3) | e_rd[e_n-1]);
      end
      check(nprobe == e_n, "R6", {tag, " probe count"}, nprobe, e_n);
      bad = 0;
      for (int i = 0; i < e_n && i < nprobe; i++) begin
         if (log_rx[i] != e_rx[i] || log_tx[i] != e_tx[i] || log_rd[i] != e_rd[i]) begin
            if (bad == 0)
               $display("FAIL R2 R3 R4 R5 %s order at probe %0d: actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                        tag, i, log_rx[i], log_tx[i], log_rd[i], e_rx[i], e_tx[i], e_rd[i]);
            bad++;
         end
      end
      n_checks++;
      if (bad != 0) n_fails++;
      check(wr_cnt == nprobe && rs_cnt == nprobe, "R8", {tag, " load/resync per probe"},
            wr_cnt + rs_cnt, 2 * nprobe);
      if (inj_done) begin
         // R10: start raised in the done cycle
         start = 1'b1; mode = m;
         @(negedge clk);
         start = 1'b0;
         repeat (3) @(negedge clk);
         check(busy == 1'b0, "R10", {tag, " no rescan after done-cycle start"}, int'(busy), 0);
      end else begin
         @(negedge clk);
      end
      check(done_cnt == 1, "R9", {tag, " single done"}, done_cnt, 1);
      check(nprobe == e_n, "R10", {tag, " no extra probes"}, nprobe, e_n);
   endtask

   initial begin
      lat = 1; win_lo = 0; win_hi = -1; win_rd = 15; win_tx = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 0 && done == 0 && found == 0, "R1", "status in reset",
            int'({busy, done, found}), 0);
      check(chk_req == 0 && dl_wr == 0 && dl_resync == 0, "R1", "strobes in reset",
            int'({chk_req, dl_wr, dl_resync}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && done == 0 && chk_req == 0, "R1", "idle after reset",
            int'({busy, done, chk_req}), 0);

      // R2/R5: receive low edge, pass only from read delay 2
      run_scan(2'b00, 16, 1, 1, 10, 40, 2, 0, 0, "rx_low");
      // R3/R4: receive high edge
      run_scan(2'b10, 48, 1, 3, 20, 30, 1, 0, 0, "rx_high");
      // R2/R7: transmit low edge, pass on end code 32 at read delay 3
      run_scan(2'b01, 20, 1, 2, 32, 50, 3, 0, 0, "tx_low_end");
      // R3/R6: transmit high edge, nothing passes
      run_scan(2'b11, 7, 1, 1, 0, -1, 15, 0, 0, "tx_high_none");
      // R7: pass on the very last candidate of the last read delay
      run_scan(2'b00, 33, 1, 1, 15, 15, 4, 0, 0, "rx_low_last");
      // R6: rd_init above the limit, no checks
      run_scan(2'b01, 5, 5, 1, 0, 63, 0, 0, 0, "rd_over");
      // R6: rd_init at the limit, receive high, nothing passes
      run_scan(2'b10, 12, 4, 2, 0, -1, 15, 0, 0, "rd_at_max");
      // R10: start in the middle of a scan
      run_scan(2'b01, 40, 2, 2, 5, 9, 3, 1, 0, "mid_start");
      // R10: start in the done cycle
      run_scan(2'b11, 3, 1, 1, 0, 55, 1, 0, 1, "done_start");

      finished = 1;
      summary();
      $finish;
   end

endmodule